// File: doc/BRIEF.md
# Single-Cycle 16-bit Processor Core

This block is a small processor that completes one instruction on every clock cycle. It fetches a 16-bit word from an internal instruction memory at the program counter and splits it into four 4-bit fields. The top field is decoded into datapath controls. The core reads two of sixteen registers, runs a four-function ALU, and may read or write an internal data memory. It then writes a register and moves the program counter to the next instruction, a branch target or a jump target.

Both memories are filled through a write port, normally while reset is held. After reset is released the core runs the program until it meets a halt instruction. Debug outputs show the current state each cycle: program counter, instruction, both register read values, the ALU result and a halted flag.

Top module: `cpu16_core`

## Requirements
- R1: The instruction fields are opcode in bits 15:12, first source in bits 11:8, second source in bits 7:4, and destination or offset in bits 3:0. The opcodes are:

  | Opcode | Instruction |
  |---|---|
  | 0 | load word |
  | 1 | store word |
  | 2 | add |
  | 3 | subtract |
  | 4 | AND |
  | 5 | OR |
  | 7 | branch if equal |
  | 8 | jump |
  | 15 | halt |

- R2: Register 0 always reads 0 and register 1 always reads 1. A write to either of them has no effect.
- R3: While reset (active low, asynchronous) is asserted, the program counter is 0, the halted flag is 0 and registers 2 to 15 are 0.
- R4: Add, subtract, AND and OR apply to the two source registers with 16-bit wraparound and write the result to the destination field. For example, 2 - 6 gives 0xFFFC.
- R5: Loads and stores form their address as the first source plus the sign-extended 4-bit offset, and the ALU output shows that address. The memory word index is address bits 8:1. A store writes the second-source register. A load writes the loaded word to the register named by the second-source field.
- R6: When the two sources are equal, branch-if-equal sets the program counter to PC + 2 + 2 × (sign-extended offset). When they differ, it sets it to PC + 2. The ALU output shows the first source minus the second.
- R7: Jump sets the program counter to twice the unsigned 12-bit field in bits 11:0. Jump and halt show the sum of the two sources on the ALU output.
- R8: Once a halt instruction is executed, the halted flag rises on that clock edge. From then on the program counter holds, register and memory writes are suppressed, and the flag stays set until reset.
- R9: A load-port write with select 0 writes the instruction memory and with select 1 writes the data memory, at the given word index.
- R10: The debug outputs reflect the instruction at the current program counter within the same cycle.
- R11: The loop program (2112, 2223, 2334, 3424, 4444, 7422, 8003, then from 0x10: 1032, 1244, 0052, 4555, 5555) must behave as follows:
  - It shows an ALU result of 6 on its first visit to PC 8.
  - It visits PC 8 three times.
  - It shows 4 on the ALU output at PC 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_we_i | input | 1 | Load-port write strobe |
| ld_sel_i | input | 1 | 0 selects instruction memory, 1 selects data memory |
| ld_addr_i | input | 8 | Load-port word index |
| ld_data_i | input | 16 | Load-port write data |
| pc_o | output | 16 | Current program counter |
| instr_o | output | 16 | Instruction at the program counter |
| rs_data_o | output | 16 | First source register value |
| rt_data_o | output | 16 | Second source register value |
| alu_res_o | output | 16 | ALU result |
| halted_o | output | 1 | Halted flag |

## Verification
The assertions take for granted that the load port is used only while reset is asserted. Otherwise a load-port write to data memory could collide with a store that the program issues. The bench keeps to this: it clears and loads both memories with reset held, and releases reset only once loading is done. The assertions also take for granted that reset is the only way out of the halted state. The bench leaves the halted state only by asserting reset.

// File: rtl/cpu16_pkg.sv
`timescale 1ns/1ps
package cpu16_pkg;
  localparam logic [3:0] OP_LW   = 4'h0;
  localparam logic [3:0] OP_SW   = 4'h1;
  localparam logic [3:0] OP_ADD  = 4'h2;
  localparam logic [3:0] OP_SUB  = 4'h3;
  localparam logic [3:0] OP_AND  = 4'h4;
  localparam logic [3:0] OP_OR   = 4'h5;
  localparam logic [3:0] OP_BEQ  = 4'h7;
  localparam logic [3:0] OP_JMP  = 4'h8;
  localparam logic [3:0] OP_HALT = 4'hF;

  typedef enum logic [3:0] {
    ALU_AND = 4'h0,
    ALU_OR  = 4'h1,
    ALU_ADD = 4'h2,
    ALU_SUB = 4'h6
  } alu_op_e;

  typedef struct packed {
    alu_op_e alu_op;
    logic    reg_we;
    logic    mem_en;
    logic    mem_st;
    logic    branch;
    logic    jump;
    logic    halt;
    logic    wr_rt;   // write-back register comes from the Rt field
    logic    imm_b;   // second ALU operand is the offset
  } ctrl_t;
endpackage

// File: rtl/cpu16_ctrl.sv
`timescale 1ns/1ps
module cpu16_ctrl
  import cpu16_pkg::*;
(
  input  logic [3:0] opcode_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_op = ALU_ADD;
    case (opcode_i)
      OP_LW: begin
        ctrl_o.reg_we = 1'b1;
        ctrl_o.mem_en = 1'b1;
        ctrl_o.wr_rt  = 1'b1;
        ctrl_o.imm_b  = 1'b1;
      end
      OP_SW: begin
        ctrl_o.mem_en = 1'b1;
        ctrl_o.mem_st = 1'b1;
        ctrl_o.imm_b  = 1'b1;
      end
      OP_ADD: ctrl_o.reg_we = 1'b1;
      OP_SUB: begin
        ctrl_o.reg_we = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      OP_AND: begin
        ctrl_o.reg_we = 1'b1;
        ctrl_o.alu_op = ALU_AND;
      end
      OP_OR: begin
        ctrl_o.reg_we = 1'b1;
        ctrl_o.alu_op = ALU_OR;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      OP_JMP:  ctrl_o.jump = 1'b1;
      OP_HALT: ctrl_o.halt = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/cpu16_alu.sv
`timescale 1ns/1ps
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         zero_o
);
  always_comb begin
    case (op_i)
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_SUB: res_o = a_i - b_i;
      default: res_o = a_i + b_i;
    endcase
  end
  assign zero_o = (res_o == '0);
endmodule

// File: rtl/cpu16_regfile.sv
`timescale 1ns/1ps
module cpu16_regfile #(
  parameter int W      = 16,
  parameter int N_REGS = 16,
  localparam int AW    = $clog2(N_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i,
  output logic [W-1:0]  rda_o,
  output logic [W-1:0]  rdb_o
);
  logic [W-1:0] regs [N_REGS];

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else if (g == 1) begin : g_one
      assign regs[g] = W'(1);
    end else begin : g_ff
      logic [W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     q <= '0;
        else if (we_i && wa_i == AW'(g)) q <= wd_i;
      end
      assign regs[g] = q;
    end
  end

  assign rda_o = regs[ra_i];
  assign rdb_o = regs[rb_i];

  a_r2_const_regs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ra_i == '0) |-> (rda_o == '0)) and ((rb_i == AW'(1)) |-> (rdb_o == W'(1))));
endmodule

// File: rtl/cpu16_core.sv
`timescale 1ns/1ps
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int DW        = 16,
  parameter int MEM_WORDS = 256,
  parameter int N_REGS    = 16,
  localparam int MAW      = $clog2(MEM_WORDS),
  localparam int RAW      = $clog2(N_REGS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ld_we_i,
  input  logic           ld_sel_i,
  input  logic [MAW-1:0] ld_addr_i,
  input  logic [DW-1:0]  ld_data_i,
  output logic [DW-1:0]  pc_o,
  output logic [DW-1:0]  instr_o,
  output logic [DW-1:0]  rs_data_o,
  output logic [DW-1:0]  rt_data_o,
  output logic [DW-1:0]  alu_res_o,
  output logic           halted_o
);
  logic [DW-1:0] imem [MEM_WORDS];
  logic [DW-1:0] dmem [MEM_WORDS];

  logic [DW-1:0] pc_q, pc_next, pc_plus2, br_tgt, jmp_tgt;
  logic          halted_q;
  logic [DW-1:0] instr, rs_data, rt_data, alu_b, alu_res, off_sext, wb_data, ld_word;
  logic [RAW-1:0] wr_addr;
  logic          alu_zero, reg_we, store_en;
  ctrl_t         ctrl;

  // fetch
  assign instr = imem[pc_q[MAW:1]];

  cpu16_ctrl u_ctrl (
    .opcode_i (instr[15:12]),
    .ctrl_o   (ctrl)
  );

  assign off_sext = {{(DW-4){instr[3]}}, instr[3:0]};
  assign wr_addr  = ctrl.wr_rt ? instr[7:4] : instr[3:0];
  assign reg_we   = ctrl.reg_we && !halted_q;
  assign ld_word  = dmem[alu_res[MAW:1]];
  assign wb_data  = ctrl.mem_en ? ld_word : alu_res;

  cpu16_regfile #(.W(DW), .N_REGS(N_REGS)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (instr[11:8]),
    .rb_i   (instr[7:4]),
    .we_i   (reg_we),
    .wa_i   (wr_addr),
    .wd_i   (wb_data),
    .rda_o  (rs_data),
    .rdb_o  (rt_data)
  );

  assign alu_b = ctrl.imm_b ? off_sext : rt_data;

  cpu16_alu #(.W(DW)) u_alu (
    .a_i    (rs_data),
    .b_i    (alu_b),
    .op_i   (ctrl.alu_op),
    .res_o  (alu_res),
    .zero_o (alu_zero)
  );

  // memories; stores blocked during reset and after halt
  assign store_en = ctrl.mem_st && !halted_q && rst_ni;

  always_ff @(posedge clk_i) begin
    if (ld_we_i && !ld_sel_i) imem[ld_addr_i] <= ld_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (ld_we_i && ld_sel_i) dmem[ld_addr_i] <= ld_data_i;
    else if (store_en)       dmem[alu_res[MAW:1]] <= rt_data;
  end

  // next PC
  assign pc_plus2 = pc_q + DW'(2);
  assign br_tgt   = pc_plus2 + {off_sext[DW-2:0], 1'b0};
  assign jmp_tgt  = {{(DW-13){1'b0}}, instr[11:0], 1'b0};

  always_comb begin
    if (halted_q || ctrl.halt)        pc_next = pc_q;
    else if (ctrl.jump)               pc_next = jmp_tgt;
    else if (ctrl.branch && alu_zero) pc_next = br_tgt;
    else                              pc_next = pc_plus2;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
    end else begin
      pc_q <= pc_next;
      if (ctrl.halt) halted_q <= 1'b1;
    end
  end

  assign pc_o      = pc_q;
  assign instr_o   = instr;
  assign rs_data_o = rs_data;
  assign rt_data_o = rt_data;
  assign alu_res_o = alu_res;
  assign halted_o  = halted_q;

  a_r8_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> halted_q);
  a_r8_pc_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> (pc_q == $past(pc_q)));
  a_r6_pc_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q[0] == 1'b0);
  a_r7_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.jump && !halted_q) |=> (pc_q == {{(DW-13){1'b0}}, $past(instr[11:0]), 1'b0}));
  a_r1_ctrl_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl.reg_we, ctrl.mem_st, ctrl.branch, ctrl.jump, ctrl.halt}));
  a_r6_seq_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_q && !ctrl.halt && !ctrl.jump && !ctrl.branch) |=> (pc_q == $past(pc_q) + DW'(2)));
endmodule

// File: tb/cpu16_core_tb.sv
`timescale 1ns/1ps
module cpu16_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_we = 1'b0;
  logic        ld_sel = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] pc, instr, rs_d, rt_d, alu;
  logic        halted;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;  // 50 MHz

  cpu16_core u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ld_we_i   (ld_we),
    .ld_sel_i  (ld_sel),
    .ld_addr_i (ld_addr),
    .ld_data_i (ld_data),
    .pc_o      (pc),
    .instr_o   (instr),
    .rs_data_o (rs_d),
    .rt_data_o (rt_d),
    .alu_res_o (alu),
    .halted_o  (halted)
  );

  typedef struct packed {
    logic [15:0] pc;
    logic [15:0] ins;
    logic [15:0] rs;
    logic [15:0] rt;
    logic [15:0] alu;
    logic        h;
  } row_t;

  localparam logic [15:0] PROG_A [19] = '{
    16'h2115, 16'h2552, 16'h5256, 16'h3563, 16'h4257, 16'h2303, 16'h2661,
    16'h2110, 16'h2008, 16'h163E, 16'h0290, 16'h2990, 16'h7991, 16'h2112,
    16'h7051, 16'h8012, 16'h2112, 16'h2112, 16'hF123};

  localparam row_t ROWS [18] = '{
    '{16'h0000, 16'h2115, 16'h0001, 16'h0001, 16'h0002, 1'b0},
    '{16'h0002, 16'h2552, 16'h0002, 16'h0002, 16'h0004, 1'b0},
    '{16'h0004, 16'h5256, 16'h0004, 16'h0002, 16'h0006, 1'b0},
    '{16'h0006, 16'h3563, 16'h0002, 16'h0006, 16'hFFFC, 1'b0},
    '{16'h0008, 16'h4257, 16'h0004, 16'h0002, 16'h0000, 1'b0},
    '{16'h000A, 16'h2303, 16'hFFFC, 16'h0000, 16'hFFFC, 1'b0},
    '{16'h000C, 16'h2661, 16'h0006, 16'h0006, 16'h000C, 1'b0},
    '{16'h000E, 16'h2110, 16'h0001, 16'h0001, 16'h0002, 1'b0},
    '{16'h0010, 16'h2008, 16'h0000, 16'h0000, 16'h0000, 1'b0},
    '{16'h0012, 16'h163E, 16'h0006, 16'hFFFC, 16'h0004, 1'b0},
    '{16'h0014, 16'h0290, 16'h0004, 16'h0000, 16'h0004, 1'b0},
    '{16'h0016, 16'h2990, 16'hFFFC, 16'hFFFC, 16'hFFF8, 1'b0},
    '{16'h0018, 16'h7991, 16'hFFFC, 16'hFFFC, 16'h0000, 1'b0},
    '{16'h001C, 16'h7051, 16'h0000, 16'h0002, 16'hFFFE, 1'b0},
    '{16'h001E, 16'h8012, 16'h0000, 16'h0001, 16'h0001, 1'b0},
    '{16'h0024, 16'hF123, 16'h0001, 16'h0004, 16'h0005, 1'b0},
    '{16'h0024, 16'hF123, 16'h0001, 16'h0004, 16'h0005, 1'b1},
    '{16'h0024, 16'hF123, 16'h0001, 16'h0004, 16'h0005, 1'b1}};

  localparam logic [15:0] PROG_B [14] = '{
    16'h2112, 16'h2223, 16'h2334, 16'h3424, 16'h4444, 16'h7422, 16'h8003,
    16'h0000, 16'h1032, 16'h1244, 16'h0052, 16'h4555, 16'h5555, 16'hF000};

  function automatic string row_req(int i);
    case (i)
      0, 1, 2, 3, 4, 5: return "R4";
      6, 7, 8:          return "R2";
      9, 10, 11:        return "R5";
      12, 13:           return "R6";
      14:               return "R7";
      default:          return "R8";
    endcase
  endfunction

  task automatic chk(string req, logic [80:0] got, logic [80:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic write_mem(logic sel, logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_sel = sel; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic clear_mems();
    for (int i = 0; i < 256; i++) begin
      write_mem(1'b0, 8'(i), 16'h0000);
      write_mem(1'b1, 8'(i), 16'h0000);
    end
  endtask

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int visits, first_alu, last_alu, last_ins;
    // program A, loaded with reset held (R9 load port)
    clear_mems();
    for (int i = 0; i < 19; i++) write_mem(1'b0, 8'(i), PROG_A[i]);
    #1;
    // R3 reset state
    chk("R3", 81'({pc, halted}), 81'({16'h0000, 1'b0}));
    chk("R10", 81'(instr), 81'(16'h2115));
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 18; i++) begin
      #1;
      chk(row_req(i), {pc, instr, rs_d, rt_d, alu, halted}, ROWS[i]);
      @(negedge clk);
    end
    // R8 halt persists for many cycles
    repeat (20) @(negedge clk);
    #1;
    chk("R8", 81'({pc, halted}), 81'({16'h0024, 1'b1}));
    // R3 reset leaves halt
    rst_n = 1'b0;
    #1;
    chk("R3", 81'({pc, halted}), 81'({16'h0000, 1'b0}));

    // loop program (R11)
    clear_mems();
    for (int i = 0; i < 14; i++) write_mem(1'b0, 8'(i), PROG_B[i]);
    @(negedge clk);
    rst_n = 1'b1;
    visits = 0; first_alu = -1; last_alu = -1; last_ins = -1;
    for (int c = 0; c < 200 && !halted; c++) begin
      #1;
      if (pc == 16'h0008) begin
        if (visits == 0) first_alu = int'(alu);
        visits++;
      end
      if (pc == 16'h0018) begin
        last_alu = int'(alu);
        last_ins = int'(instr);
      end
      @(negedge clk);
    end
    #1;
    chk("R11", 81'(first_alu), 81'(6));
    chk("R11", 81'(visits), 81'(3));
    chk("R11", 81'(last_alu), 81'(4));
    chk("R11", 81'(last_ins), 81'(16'h5555));
    chk("R8", 81'({pc, halted}), 81'({16'h001A, 1'b1}));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule